// File: doc/BRIEF.md
# Coprocessor Execute Unit with Stage Counter

This block is the arithmetic execute stage of a small coprocessor with four 16-bit general registers. Each accepted command either combines two register operands, or combines a register with a 16-bit immediate. It writes the result to a destination register and records a zero flag and an overflow flag. A later absolute-branch unit reads these flags.

Beside the register datapath the block owns an 8-bit stage counter. Loop-control commands step it up by an immediate, step it down by an immediate, or clear it. Relative-branch logic compares the counter's value. The branch units and the host sequencer see the register contents through one combinational read port, and see the flags and the counter as plain status outputs.

Commands arrive on a valid-qualified interface with no ready signal. The unit completes every command in the cycle it is presented, so there is no back-pressure. The sender may present a new command on every clock. A cycle with `cmd_valid` low is a bubble and changes nothing.

Top module: `stalu_core`

## Requirements
- R1: After reset all four registers read 0, both flags are 0 and the stage counter is 0.
- R2: Select 0 adds and select 1 subtracts (first operand minus second). The 16-bit result goes to the destination register. The overflow flag takes the carry out of bit 15 for add and the borrow for subtract. The zero flag is set exactly when the 16-bit result is 0.
- R3: Select 2 (AND), select 3 (OR), select 4 (move), select 5 and select 6 (shifts) clear the overflow flag. They set the zero flag from their result.
- R4: Select 5 shifts the first operand left and select 6 shifts it right (logical), by the value of the second operand. Any count of 16 or more gives 0.
- R5: Command class 1 takes the second operand from the 16-bit immediate. A move in this class writes the immediate.
- R6: Command class 0 takes the second operand from the register at index `cmd_src_b`. A move in this class copies the register at index `cmd_src_a`.
- R7: In command class 2, select 0 adds the immediate's low 8 bits to the stage counter and select 1 subtracts them, both wrapping modulo 256. Select 2 clears the counter.
- R8: Class 2 commands leave all registers and both flags unchanged.
- R9: These leave registers, flags and counter unchanged: a cycle with `cmd_valid` low, a select of 7 or above in classes 0 and 1, a select of 3 or above in class 2, and class 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_class | input | 2 | 0 register-register, 1 register-immediate, 2 stage counter, 3 reserved |
| cmd_sel | input | 4 | Operation select |
| cmd_dst | input | 2 | Destination register index |
| cmd_src_a | input | 2 | First operand register index |
| cmd_src_b | input | 2 | Second operand register index (class 0) |
| cmd_imm | input | 16 | Immediate operand |
| rd_idx | input | 2 | Register index for the read port |
| rd_data | output | 16 | Register contents at `rd_idx`, combinational |
| zero_flag | output | 1 | Last ALU result was zero |
| ovf_flag | output | 1 | Last ALU operation carried or borrowed |
| stage_cnt | output | 8 | Stage counter value |

## Verification
Every piece of state in this unit is visible at a port: the registers through `rd_data`, and the flags and the counter directly. A wrong write, a wrong operand selection or a wrong flag update therefore shows in the cycle after the clock edge that accepts the command. There are no buried pipeline stages. A wrong destination index is the subtle case. The register that should have changed keeps its old value, and a different register is corrupted, which a later vector shows when it reads that register. A flag update made on a stage or ignored command shows as a flag that moves when the next status sample expects it to hold.

// File: rtl/stalu_pkg.sv
package stalu_pkg;

  typedef enum logic [1:0] {
    CLS_REG   = 2'd0,
    CLS_IMM   = 2'd1,
    CLS_STAGE = 2'd2,
    CLS_RSVD  = 2'd3
  } cmd_class_e;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_MOV = 4'd4,
    OP_LSH = 4'd5,
    OP_RSH = 4'd6
  } alu_op_e;

  typedef enum logic [3:0] {
    STG_INC = 4'd0,
    STG_DEC = 4'd1,
    STG_CLR = 4'd2
  } stage_op_e;

endpackage

// File: rtl/stalu_regfile.sv
module stalu_regfile #(
  parameter int DATA_W = 16,
  parameter int NREGS  = 4,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [IDX_W-1:0]  rx_idx,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic [DATA_W-1:0] rx_data
);

  logic [DATA_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        regs[g] <= wr_data;
      end
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
  assign rx_data = regs[rx_idx];

endmodule

// File: rtl/stalu_datapath.sv
module stalu_datapath
  import stalu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  alu_op_e           op,
  input  logic              imm_form,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              op_known
);

  logic [DATA_W:0]   sum_ext;
  logic [DATA_W:0]   dif_ext;
  logic              shift_all_out;
  logic [SH_W-1:0]   shamt;

  assign sum_ext       = {1'b0, opa} + {1'b0, opb};
  assign dif_ext       = {1'b0, opa} - {1'b0, opb};
  // Counts at or beyond the word width push every bit out.
  assign shift_all_out = |opb[DATA_W-1:SH_W];
  assign shamt         = opb[SH_W-1:0];

  always_comb begin
    result   = '0;
    ovf      = 1'b0;
    op_known = 1'b1;
    unique case (op)
      OP_ADD: begin
        result = sum_ext[DATA_W-1:0];
        ovf    = sum_ext[DATA_W];
      end
      OP_SUB: begin
        result = dif_ext[DATA_W-1:0];
        ovf    = dif_ext[DATA_W];
      end
      OP_AND: result = opa & opb;
      OP_OR:  result = opa | opb;
      OP_MOV: result = imm_form ? opb : opa;
      OP_LSH: result = shift_all_out ? '0 : (opa << shamt);
      OP_RSH: result = shift_all_out ? '0 : (opa >> shamt);
      default: op_known = 1'b0;
    endcase
  end

endmodule

// File: rtl/stalu_stage.sv
module stalu_stage
  import stalu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  stage_op_e        op,
  input  logic [CNT_W-1:0] step,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (en) begin
      unique case (op)
        STG_INC: count_q <= count_q + step;
        STG_DEC: count_q <= count_q - step;
        STG_CLR: count_q <= '0;
        default: count_q <= count_q;
      endcase
    end
  end

  assign count = count_q;

endmodule

// File: rtl/stalu_core.sv
module stalu_core
  import stalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREGS  = 4,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_class,
  input  logic [3:0]        cmd_sel,
  input  logic [IDX_W-1:0]  cmd_dst,
  input  logic [IDX_W-1:0]  cmd_src_a,
  input  logic [IDX_W-1:0]  cmd_src_b,
  input  logic [DATA_W-1:0] cmd_imm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              zero_flag,
  output logic              ovf_flag,
  output logic [CNT_W-1:0]  stage_cnt
);

  cmd_class_e        cls;
  logic              is_reg, is_imm, is_stage;
  logic [DATA_W-1:0] ra, rb, opb;
  logic [DATA_W-1:0] alu_res;
  logic              alu_ovf, alu_known;
  logic              alu_commit;
  logic              zero_q, ovf_q;

  assign cls      = cmd_class_e'(cmd_class);
  assign is_reg   = (cls == CLS_REG);
  assign is_imm   = (cls == CLS_IMM);
  assign is_stage = (cls == CLS_STAGE);
  assign opb      = is_imm ? cmd_imm : rb;

  stalu_datapath #(.DATA_W(DATA_W)) u_dp (
    .op       (alu_op_e'(cmd_sel)),
    .imm_form (is_imm),
    .opa      (ra),
    .opb      (opb),
    .result   (alu_res),
    .ovf      (alu_ovf),
    .op_known (alu_known)
  );

  assign alu_commit = cmd_valid && (is_reg || is_imm) && alu_known;

  stalu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (alu_commit),
    .wr_idx  (cmd_dst),
    .wr_data (alu_res),
    .ra_idx  (cmd_src_a),
    .rb_idx  (cmd_src_b),
    .rx_idx  (rd_idx),
    .ra_data (ra),
    .rb_data (rb),
    .rx_data (rd_data)
  );

  // Flags are sticky: only a committed ALU operation moves them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (alu_commit) begin
      zero_q <= (alu_res == '0);
      ovf_q  <= alu_ovf;
    end
  end

  assign zero_flag = zero_q;
  assign ovf_flag  = ovf_q;

  stalu_stage #(.CNT_W(CNT_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cmd_valid && is_stage),
    .op    (stage_op_e'(cmd_sel)),
    .step  (cmd_imm[CNT_W-1:0]),
    .count (stage_cnt)
  );

endmodule

// File: rtl/stalu_checker.sv
module stalu_checker #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_class,
  input logic [3:0]        cmd_sel,
  input logic [DATA_W-1:0] cmd_imm,
  input logic              zero_flag,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  stage_cnt
);

  logic alu_cls;
  assign alu_cls = cmd_valid && (cmd_class < 2'd2);

  // R3: logical, move and shift operations leave overflow clear
  assert_ovf_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_cls && cmd_sel >= 4'd2 && cmd_sel <= 4'd6) |=> !ovf_flag);

  // R4: a shift by 16 or more gives a zero result
  assert_wide_shift_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 2'd1 && (cmd_sel == 4'd5 || cmd_sel == 4'd6)
     && cmd_imm >= DATA_W'(DATA_W)) |=> zero_flag);

  // R7: increment wraps modulo the counter width
  assert_stage_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 2'd2 && cmd_sel == 4'd0) |=>
      stage_cnt == CNT_W'($past(stage_cnt) + $past(cmd_imm[CNT_W-1:0])));

  // R7: clear command
  assert_stage_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 2'd2 && cmd_sel == 4'd2) |=> stage_cnt == '0);

  // R8: stage commands do not touch the flags
  assert_stage_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 2'd2) |=> ($stable(zero_flag) && $stable(ovf_flag)));

  // R9: bubbles change no status
  assert_bubble_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(zero_flag) && $stable(ovf_flag) && $stable(stage_cnt)));

  // R9: reserved command class changes nothing visible in status
  assert_reserved_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 2'd3) |=>
      ($stable(zero_flag) && $stable(ovf_flag) && $stable(stage_cnt)));

endmodule

bind stalu_core stalu_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_class (cmd_class),
  .cmd_sel   (cmd_sel),
  .cmd_imm   (cmd_imm),
  .zero_flag (zero_flag),
  .ovf_flag  (ovf_flag),
  .stage_cnt (stage_cnt)
);

// File: tb/stalu_core_bench.sv
module stalu_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_class = '0;
  logic [3:0]  cmd_sel = '0;
  logic [1:0]  cmd_dst = '0, cmd_src_a = '0, cmd_src_b = '0;
  logic [15:0] cmd_imm = '0;
  logic [1:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic        zero_flag, ovf_flag;
  logic [7:0]  stage_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stalu_core u_stalu_core (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
    .cmd_sel(cmd_sel), .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a),
    .cmd_src_b(cmd_src_b), .cmd_imm(cmd_imm), .rd_idx(rd_idx),
    .rd_data(rd_data), .zero_flag(zero_flag), .ovf_flag(ovf_flag),
    .stage_cnt(stage_cnt)
  );

  // Vector: class, sel, dst, src_a, src_b, imm | read idx, expected read
  // value, zero, ovf, counter, requirement number
  localparam logic [59:0] VECS [NV] = '{
    {2'd1,4'd4,2'd0,2'd0,2'd0,16'hFFFF, 2'd0,16'hFFFF,1'b0,1'b0,8'h00,4'd5}, // R5 move imm
    {2'd1,4'd0,2'd1,2'd0,2'd0,16'h0001, 2'd1,16'h0000,1'b1,1'b1,8'h00,4'd2}, // R2 add carry
    {2'd1,4'd4,2'd2,2'd0,2'd0,16'h1234, 2'd2,16'h1234,1'b0,1'b0,8'h00,4'd5}, // R5
    {2'd0,4'd4,2'd3,2'd2,2'd0,16'h0000, 2'd3,16'h1234,1'b0,1'b0,8'h00,4'd6}, // R6 move reg
    {2'd0,4'd1,2'd1,2'd3,2'd2,16'h0000, 2'd1,16'h0000,1'b1,1'b0,8'h00,4'd2}, // R2 sub zero
    {2'd1,4'd1,2'd1,2'd1,2'd0,16'h0001, 2'd1,16'hFFFF,1'b0,1'b1,8'h00,4'd2}, // R2 borrow
    {2'd0,4'd2,2'd3,2'd0,2'd2,16'h0000, 2'd3,16'h1234,1'b0,1'b0,8'h00,4'd3}, // R3 AND
    {2'd1,4'd3,2'd3,2'd3,2'd0,16'h00F0, 2'd3,16'h12F4,1'b0,1'b0,8'h00,4'd3}, // R3 OR
    {2'd1,4'd0,2'd2,2'd2,2'd0,16'h0001, 2'd2,16'h1235,1'b0,1'b0,8'h00,4'd2}, // R2
    {2'd1,4'd5,2'd1,2'd2,2'd0,16'h0004, 2'd1,16'h2350,1'b0,1'b0,8'h00,4'd4}, // R4 lsh
    {2'd1,4'd6,2'd1,2'd2,2'd0,16'h0008, 2'd1,16'h0012,1'b0,1'b0,8'h00,4'd4}, // R4 rsh
    {2'd1,4'd5,2'd1,2'd2,2'd0,16'h0010, 2'd1,16'h0000,1'b1,1'b0,8'h00,4'd4}, // R4 count 16
    {2'd1,4'd6,2'd1,2'd0,2'd0,16'h000F, 2'd1,16'h0001,1'b0,1'b0,8'h00,4'd4}, // R4 count 15
    {2'd1,4'd0,2'd1,2'd0,2'd0,16'h0002, 2'd1,16'h0001,1'b0,1'b1,8'h00,4'd2}, // R2 carry
    {2'd2,4'd0,2'd1,2'd0,2'd0,16'h0105, 2'd1,16'h0001,1'b0,1'b1,8'h05,4'd7}, // R7 low byte
    {2'd2,4'd1,2'd0,2'd0,2'd0,16'h0006, 2'd1,16'h0001,1'b0,1'b1,8'hFF,4'd7}, // R7 wrap down
    {2'd2,4'd0,2'd0,2'd0,2'd0,16'h0001, 2'd0,16'hFFFF,1'b0,1'b1,8'h00,4'd7}, // R7 wrap up
    {2'd2,4'd0,2'd0,2'd0,2'd0,16'h0030, 2'd1,16'h0001,1'b0,1'b1,8'h30,4'd8}, // R8
    {2'd2,4'd2,2'd0,2'd0,2'd0,16'h00AA, 2'd1,16'h0001,1'b0,1'b1,8'h00,4'd7}, // R7 clear
    {2'd2,4'd3,2'd0,2'd0,2'd0,16'h0005, 2'd1,16'h0001,1'b0,1'b1,8'h00,4'd9}, // R9 bad stage sel
    {2'd1,4'd7,2'd1,2'd0,2'd0,16'h0000, 2'd1,16'h0001,1'b0,1'b1,8'h00,4'd9}, // R9 bad alu sel
    {2'd3,4'd0,2'd1,2'd0,2'd0,16'h0000, 2'd1,16'h0001,1'b0,1'b1,8'h00,4'd9}, // R9 class 3
    {2'd0,4'd0,2'd2,2'd1,2'd1,16'h0000, 2'd2,16'h0002,1'b0,1'b0,8'h00,4'd2}, // R2 reg add
    {2'd0,4'd5,2'd3,2'd3,2'd1,16'h0000, 2'd3,16'h25E8,1'b0,1'b0,8'h00,4'd4}  // R4 reg count
  };

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_reset(string tag);
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #1;
      check("R1", $sformatf("%s reg %0d", tag, i), rd_data, 16'h0000);
    end
    check("R1", {tag, " zero"}, 16'(zero_flag), 16'h0);
    check("R1", {tag, " ovf"}, 16'(ovf_flag), 16'h0);
    check("R1", {tag, " stage"}, 16'(stage_cnt), 16'h0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] r1_before;
    repeat (3) @(negedge clk);
    check_reset("R1 initial");
    rst_n = 1'b1;

    // R9: bubble with garbage on the command fields
    @(negedge clk);
    cmd_valid = 1'b0; cmd_class = 2'd1; cmd_sel = 4'd4; cmd_dst = 2'd2; cmd_imm = 16'hBEEF;
    @(posedge clk); #1;
    rd_idx = 2'd2; #1;
    check("R9", "bubble reg", rd_data, 16'h0000);
    check("R9", "bubble stage", 16'(stage_cnt), 16'h0);

    for (int k = 0; k < NV; k++) begin
      logic [59:0] v;
      string req;
      v = VECS[k];
      req = $sformatf("R%0d", v[3:0]);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_class = v[59:58]; cmd_sel = v[57:54]; cmd_dst = v[53:52];
      cmd_src_a = v[51:50]; cmd_src_b = v[49:48]; cmd_imm = v[47:32];
      rd_idx = v[31:30];
      @(posedge clk); #1;
      check(req, $sformatf("vec %0d data", k), rd_data, v[29:14]);
      check(req, $sformatf("vec %0d zero", k), 16'(zero_flag), 16'(v[13]));
      check(req, $sformatf("vec %0d ovf", k), 16'(ovf_flag), 16'(v[12]));
      check(req, $sformatf("vec %0d stage", k), 16'(stage_cnt), 16'(v[11:4]));
    end

    // R9: bubble after activity leaves state as it was
    @(negedge clk);
    rd_idx = 2'd1; #1;
    r1_before = rd_data;
    cmd_valid = 1'b0; cmd_class = 2'd1; cmd_sel = 4'd0; cmd_dst = 2'd1; cmd_imm = 16'h7777;
    @(posedge clk); #1;
    check("R9", "late bubble reg", rd_data, r1_before);
    check("R9", "late bubble zero", 16'(zero_flag), 16'h0);

    // R7: step a nonzero counter down to exactly zero
    @(negedge clk);
    cmd_valid = 1'b1; cmd_class = 2'd2; cmd_sel = 4'd0; cmd_imm = 16'h0080;
    @(posedge clk); #1;
    check("R7", "stage up 80", 16'(stage_cnt), 16'h0080);
    @(negedge clk);
    cmd_sel = 4'd1; cmd_imm = 16'hFF80;
    @(posedge clk); #1;
    check("R7", "stage down to 0", 16'(stage_cnt), 16'h0000);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check_reset("R1 mid-run");
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule